// File: doc/BRIEF.md
# XON/XOFF Software Flow Controller

This block adds in-band flow control to a serial port, leaving the UART framing to the neighbouring logic. On the receive path it compares each incoming byte against two programmable 8-bit control characters: a stop character (XOFF) and a resume character (XON). A matching byte raises a one-cycle event pulse. When stripping is enabled, the matching byte is also kept out of the forwarded byte stream. A received stop character makes the local transmitter pause, but the pause takes effect only at a byte boundary. A received resume character, or a software force pulse, lets the transmitter run again.

On the other side, the block watches the fill level of the local receive FIFO. When the level climbs above the stop threshold, it asks the transmitter to send XOFF. When the level later drops below the resume threshold, it asks for XON. Each request is made exactly once per crossing. It is held, with its character, until the transmitter grants it. The transmitter is expected to place a granted control character ahead of any queued data, and to do so even while paused.

Two state machines carry the behaviour. The pause machine has the states RUN, DRAIN and HOLD:
- RUN goes to HOLD when a stop arrives while the transmitter is idle (stop_idle), and to DRAIN when it arrives while a byte is in flight (stop_busy).
- DRAIN goes to HOLD when the transmitter goes idle (boundary).
- DRAIN and HOLD go back to RUN on a resume (resume).

The emission machine has the states GO, ASK_OFF, STOPPED and ASK_ON:
- GO goes to ASK_OFF when the fill level exceeds the stop threshold (over).
- ASK_OFF goes to STOPPED on a grant (sent_off).
- STOPPED goes to ASK_ON when the fill level is below the resume threshold (under).
- ASK_ON goes to GO on a grant (sent_on).

Clearing the enable drives both machines to RUN and GO (disable).

Top module: `xflow_ctrl`

## Requirements
- R1: The forwarded byte appears on out_valid/out_data one cycle after rx_valid. A byte equal to either control character is withheld when both cfg_enable and cfg_strip are 1. Every other byte, and every byte while stripping or flow control is off, is forwarded unchanged.
- R2: With cfg_enable=1, a received byte equal to cfg_xon_char pulses ev_xon one cycle later, and a byte equal to cfg_xoff_char pulses ev_xoff, whether or not stripping is on. If both characters are equal, only ev_xoff pulses.
- R3: A stop cause is either an ev_xoff pulse or a force_xoff pulse. After a stop cause, tx_pause rises at the first clock edge at which tx_busy=0, so it never rises after a cycle with tx_busy=1.
- R4: A resume cause is an ev_xon pulse or a force_xon pulse, with no force_xoff in the same cycle. After a resume cause, tx_pause is 0 from the next cycle on. A resume also cancels a pending stop in DRAIN.
- R5: With cfg_enable=0, no byte is withheld, no event pulses, tx_pause is 0 one cycle later, and send_req is 0 one cycle later.
- R6: From GO, a fifo_level strictly above cfg_stop_level raises send_req in the next cycle, with send_char = cfg_xoff_char.
- R7: From STOPPED, a fifo_level strictly below cfg_go_level raises send_req with send_char = cfg_xon_char. Between the two crossings, no further request is made, however long the level stays beyond a threshold.
- R8: A raised send_req stays 1 until a cycle in which send_grant=1, and it is 0 in the cycle after that grant.
- R9: force_xoff has priority over force_xon and over a received resume in the same cycle. force_xon overrides a pending or active pause from received XOFF.
- R10: After reset, out_valid, ev_xon, ev_xoff, tx_pause and send_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Flow control on |
| cfg_strip | input | 1 | Remove matched control characters from the stream |
| cfg_xon_char | input | 8 | Resume character |
| cfg_xoff_char | input | 8 | Stop character |
| cfg_stop_level | input | LEVEL_W | Fill level above which XOFF is requested |
| cfg_go_level | input | LEVEL_W | Fill level below which XON is requested |
| force_xon | input | 1 | Pulse: resume the transmitter |
| force_xoff | input | 1 | Pulse: pause the transmitter |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded byte |
| ev_xon | output | 1 | Resume character received |
| ev_xoff | output | 1 | Stop character received |
| fifo_level | input | LEVEL_W | Local receive FIFO fill level |
| tx_busy | input | 1 | Transmitter is mid-byte |
| tx_pause | output | 1 | Transmitter must not start a new data byte |
| send_req | output | 1 | Request to send a control character |
| send_char | output | 8 | Character to send while send_req is 1 |
| send_grant | input | 1 | Transmitter takes the requested character |

## Verification
The bench targets several corner cases, each of which exposes a distinct mistake:
- A stop character that arrives while the transmitter is busy. A design that paused at once would cut a byte in half.
- A resume that arrives while a stop is still pending. A design that ignored it would freeze the link.
- The fill level parked beyond a threshold for many cycles. A design that compared levels instead of tracking crossings would flood the line with repeated requests.
- Simultaneous force pulses, equal XON and XOFF characters, a delayed grant, and operation with flow control disabled. These catch wrong priorities, double events, dropped requests, and stray stripping or pausing.

// File: rtl/xflow_pkg.sv
package xflow_pkg;
    typedef enum logic [1:0] {
        P_RUN   = 2'd0,
        P_DRAIN = 2'd1,
        P_HOLD  = 2'd2
    } pause_st_t;

    typedef enum logic [1:0] {
        E_GO      = 2'd0,
        E_ASK_OFF = 2'd1,
        E_STOPPED = 2'd2,
        E_ASK_ON  = 2'd3
    } emit_st_t;
endpackage

// File: rtl/xf_rx_filter.sv
module xf_rx_filter #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_strip,
    input  logic [CHAR_W-1:0] xon_char,
    input  logic [CHAR_W-1:0] xoff_char,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_data,
    output logic              ev_xon,
    output logic              ev_xoff
);
    logic hit_off, hit_on, drop;

    // The stop character wins when both characters are equal.
    always_comb begin
        hit_off = rx_valid && cfg_enable && (rx_data == xoff_char);
        hit_on  = rx_valid && cfg_enable && (rx_data == xon_char) && !hit_off;
        drop    = cfg_strip && (hit_on || hit_off);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            ev_xon    <= 1'b0;
            ev_xoff   <= 1'b0;
        end else begin
            out_valid <= rx_valid && !drop;
            if (rx_valid) out_data <= rx_data;
            ev_xon    <= hit_on;
            ev_xoff   <= hit_off;
        end
    end

    // R1
    strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_enable && cfg_strip && (rx_data == xon_char || rx_data == xoff_char)) |=> !out_valid);

    // R1
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_enable) |=> (out_valid && out_data == $past(rx_data)));

    // R2
    ev_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_enable && rx_data == xoff_char) |=> (ev_xoff && !ev_xon));
endmodule

// File: rtl/xf_pause_fsm.sv
module xf_pause_fsm
    import xflow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_enable,
    input  logic ev_xon,
    input  logic ev_xoff,
    input  logic force_xon,
    input  logic force_xoff,
    input  logic tx_busy,
    output logic tx_pause
);
    pause_st_t state_q, state_d;
    logic      stop_cause, resume_cause;

    always_comb begin
        stop_cause   = force_xoff || (!force_xon && !ev_xon && ev_xoff);
        resume_cause = !force_xoff && (force_xon || ev_xon);
        state_d      = state_q;
        if (!cfg_enable) begin
            state_d = P_RUN;                         // disable
        end else if (stop_cause) begin
            if (state_q == P_HOLD) state_d = P_HOLD;
            else if (tx_busy)      state_d = P_DRAIN; // stop_busy
            else                   state_d = P_HOLD;  // stop_idle
        end else if (resume_cause) begin
            state_d = P_RUN;                         // resume
        end else begin
            unique case (state_q)
                P_RUN:   state_d = P_RUN;
                P_DRAIN: state_d = tx_busy ? P_DRAIN : P_HOLD; // boundary
                P_HOLD:  state_d = P_HOLD;
                default: state_d = P_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= P_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        tx_pause = (state_q == P_HOLD);
    end

    // R3
    boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_pause) |-> $past(!tx_busy));

    // R4
    resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && !force_xoff && (force_xon || ev_xon)) |=> !tx_pause);

    // R5
    off_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !tx_pause);
endmodule

// File: rtl/xf_level_fsm.sv
module xf_level_fsm
    import xflow_pkg::*;
#(
    parameter int CHAR_W  = 8,
    parameter int LEVEL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic [CHAR_W-1:0]  xon_char,
    input  logic [CHAR_W-1:0]  xoff_char,
    input  logic [LEVEL_W-1:0] stop_level,
    input  logic [LEVEL_W-1:0] go_level,
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic               send_grant,
    output logic               send_req,
    output logic [CHAR_W-1:0]  send_char
);
    emit_st_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!cfg_enable) begin
            state_d = E_GO;                                         // disable
        end else begin
            unique case (state_q)
                E_GO:      if (fifo_level > stop_level) state_d = E_ASK_OFF; // over
                E_ASK_OFF: if (send_grant)              state_d = E_STOPPED; // sent_off
                E_STOPPED: if (fifo_level < go_level)   state_d = E_ASK_ON;  // under
                E_ASK_ON:  if (send_grant)              state_d = E_GO;      // sent_on
                default:   state_d = E_GO;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= E_GO;
        else        state_q <= state_d;
    end

    always_comb begin
        send_req  = 1'b0;
        send_char = '0;
        unique case (state_q)
            E_ASK_OFF: begin send_req = 1'b1; send_char = xoff_char; end
            E_ASK_ON:  begin send_req = 1'b1; send_char = xon_char;  end
            default:   begin send_req = 1'b0; send_char = '0;        end
        endcase
    end

    // R6
    cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(send_req) |-> $past(fifo_level > stop_level || fifo_level < go_level));

    // R8
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && send_req && !send_grant) |=> send_req);

    // R8
    drop_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (send_req && send_grant) |=> !send_req);

    // R5
    off_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !send_req);
endmodule

// File: rtl/xflow_ctrl.sv
module xflow_ctrl #(
    parameter int CHAR_W  = 8,
    parameter int LEVEL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic               cfg_strip,
    input  logic [CHAR_W-1:0]  cfg_xon_char,
    input  logic [CHAR_W-1:0]  cfg_xoff_char,
    input  logic [LEVEL_W-1:0] cfg_stop_level,
    input  logic [LEVEL_W-1:0] cfg_go_level,
    input  logic               force_xon,
    input  logic               force_xoff,
    input  logic               rx_valid,
    input  logic [CHAR_W-1:0]  rx_data,
    output logic               out_valid,
    output logic [CHAR_W-1:0]  out_data,
    output logic               ev_xon,
    output logic               ev_xoff,
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic               tx_busy,
    output logic               tx_pause,
    output logic               send_req,
    output logic [CHAR_W-1:0]  send_char,
    input  logic               send_grant
);
    xf_rx_filter #(.CHAR_W(CHAR_W)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_enable(cfg_enable),
        .cfg_strip (cfg_strip),
        .xon_char  (cfg_xon_char),
        .xoff_char (cfg_xoff_char),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .ev_xon    (ev_xon),
        .ev_xoff   (ev_xoff)
    );

    xf_pause_fsm u_pause (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_enable(cfg_enable),
        .ev_xon    (ev_xon),
        .ev_xoff   (ev_xoff),
        .force_xon (force_xon),
        .force_xoff(force_xoff),
        .tx_busy   (tx_busy),
        .tx_pause  (tx_pause)
    );

    xf_level_fsm #(.CHAR_W(CHAR_W), .LEVEL_W(LEVEL_W)) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_enable(cfg_enable),
        .xon_char  (cfg_xon_char),
        .xoff_char (cfg_xoff_char),
        .stop_level(cfg_stop_level),
        .go_level  (cfg_go_level),
        .fifo_level(fifo_level),
        .send_grant(send_grant),
        .send_req  (send_req),
        .send_char (send_char)
    );
endmodule

// File: tb/test_xflow_ctrl.sv
module test_xflow_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 1'b0, cfg_strip = 1'b0;
    logic [7:0] cfg_xon_char = 8'h11, cfg_xoff_char = 8'h13;
    logic [LW-1:0] cfg_stop_level = 8'd12, cfg_go_level = 8'd4;
    logic force_xon = 1'b0, force_xoff = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic out_valid, ev_xon, ev_xoff, tx_pause, send_req;
    logic [7:0] out_data, send_char;
    logic [LW-1:0] fifo_level = '0;
    logic tx_busy = 1'b0, send_grant = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // behavioural reference state
    int m_ov, m_od, m_eon, m_eoff, m_pause, m_emit;

    always #(CLK_PERIOD/2) clk = ~clk;

    xflow_ctrl i_xflow_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_strip(cfg_strip),
        .cfg_xon_char(cfg_xon_char), .cfg_xoff_char(cfg_xoff_char),
        .cfg_stop_level(cfg_stop_level), .cfg_go_level(cfg_go_level),
        .force_xon(force_xon), .force_xoff(force_xoff),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .out_valid(out_valid), .out_data(out_data), .ev_xon(ev_xon), .ev_xoff(ev_xoff),
        .fifo_level(fifo_level), .tx_busy(tx_busy), .tx_pause(tx_pause),
        .send_req(send_req), .send_char(send_char), .send_grant(send_grant)
    );

    always @(posedge clk or negedge rst_n) begin : model
        int np, ne;
        bit hon, hoff, stop_c, resume_c;
        if (!rst_n) begin
            m_ov = 0; m_od = 0; m_eon = 0; m_eoff = 0; m_pause = 0; m_emit = 0;
        end else begin
            hoff = rx_valid && cfg_enable && (rx_data == cfg_xoff_char);
            hon  = rx_valid && cfg_enable && (rx_data == cfg_xon_char) && !hoff;
            stop_c   = force_xoff || (!force_xon && m_eon == 0 && m_eoff == 1);
            resume_c = force_xon || m_eon == 1;
            if (!cfg_enable) np = 0;
            else if (stop_c) np = (m_pause == 2) ? 2 : (tx_busy ? 1 : 2);
            else if (resume_c) np = 0;
            else if (m_pause == 1 && !tx_busy) np = 2;
            else np = m_pause;
            if (!cfg_enable) ne = 0;
            else begin
                ne = m_emit;
                if (m_emit == 0 && fifo_level > cfg_stop_level) ne = 1;
                if (m_emit == 1 && send_grant) ne = 2;
                if (m_emit == 2 && fifo_level < cfg_go_level) ne = 3;
                if (m_emit == 3 && send_grant) ne = 0;
            end
            m_ov = (rx_valid && !(cfg_strip && (hon || hoff))) ? 1 : 0;
            if (rx_valid) m_od = int'(rx_data);
            m_eon = hon ? 1 : 0;
            m_eoff = hoff ? 1 : 0;
            m_pause = np;
            m_emit = ne;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        check("R1 out_valid", int'(out_valid), m_ov);
        if (m_ov == 1) check("R1 out_data", int'(out_data), m_od);
        check("R2 ev_xon", int'(ev_xon), m_eon);
        check("R2 ev_xoff", int'(ev_xoff), m_eoff);
        check("R3 tx_pause", int'(tx_pause), (m_pause == 2) ? 1 : 0);
        check("R6 send_req", int'(send_req), (m_emit == 1 || m_emit == 3) ? 1 : 0);
        if (m_emit == 1) check("R6 send_char", int'(send_char), int'(cfg_xoff_char));
        if (m_emit == 3) check("R7 send_char", int'(send_char), int'(cfg_xon_char));
    endtask

    task automatic rx_byte(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        step();
        rx_valid = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R10 reset values
        check("R10 out_valid", int'(out_valid), 0);
        check("R10 ev", int'(ev_xon | ev_xoff), 0);
        check("R10 tx_pause", int'(tx_pause), 0);
        check("R10 send_req", int'(send_req), 0);
        rst_n = 1'b1;
        step();
        cfg_enable = 1'b1; cfg_strip = 1'b1;
        step();
        rx_byte(8'h41);
        check("R1 plain byte", int'(out_valid), 1);
        // stop arrives with transmitter busy
        tx_busy = 1'b1;
        rx_byte(8'h13);
        check("R1 xoff stripped", int'(out_valid), 0);
        check("R2 xoff event", int'(ev_xoff), 1);
        step(); step();
        check("R3 waits for boundary", int'(tx_pause), 0);
        tx_busy = 1'b0;
        step();
        check("R3 paused at boundary", int'(tx_pause), 1);
        rx_byte(8'h11);
        check("R2 xon event", int'(ev_xon), 1);
        step();
        check("R4 resumed", int'(tx_pause), 0);
        // resume cancels a pending stop
        tx_busy = 1'b1;
        rx_byte(8'h13); step();
        rx_byte(8'h11); step();
        tx_busy = 1'b0; step(); step();
        check("R4 pending stop cancelled", int'(tx_pause), 0);
        // stripping off
        cfg_strip = 1'b0;
        rx_byte(8'h13);
        check("R1 xoff passed when strip off", int'(out_valid), 1);
        step(); step();
        cfg_strip = 1'b1;
        // force controls
        force_xon = 1'b1; step(); force_xon = 1'b0; step();
        check("R9 force_xon resumes", int'(tx_pause), 0);
        force_xoff = 1'b1; step(); force_xoff = 1'b0; step();
        check("R9 force_xoff pauses", int'(tx_pause), 1);
        force_xon = 1'b1; step(); force_xon = 1'b0; step();
        check("R9 force_xon clears", int'(tx_pause), 0);
        force_xon = 1'b1; force_xoff = 1'b1; step();
        force_xon = 1'b0; force_xoff = 1'b0; step();
        check("R9 force_xoff priority", int'(tx_pause), 1);
        force_xon = 1'b1; step(); force_xon = 1'b0; step();
        // fill level crossings
        for (int l = 0; l <= 13; l++) begin fifo_level = LW'(l); step(); end
        check("R6 xoff requested", int'(send_req), 1);
        check("R6 xoff char", int'(send_char), 8'h13);
        fifo_level = 8'd20;
        step(); step();
        check("R8 held without grant", int'(send_req), 1);
        send_grant = 1'b1; step(); send_grant = 1'b0; step();
        check("R8 released after grant", int'(send_req), 0);
        for (int k = 0; k < 8; k++) begin
            step();
            check("R7 no repeat request", int'(send_req), 0);
        end
        fifo_level = 8'd4; step(); step();
        check("R7 not below threshold yet", int'(send_req), 0);
        fifo_level = 8'd3; step(); step();
        check("R7 xon requested", int'(send_req), 1);
        check("R7 xon char", int'(send_char), 8'h11);
        send_grant = 1'b1; step(); send_grant = 1'b0; step();
        check("R8 xon released", int'(send_req), 0);
        // disabled operation
        force_xoff = 1'b1; step(); force_xoff = 1'b0;
        cfg_enable = 1'b0; step();
        check("R5 no pause when disabled", int'(tx_pause), 0);
        rx_byte(8'h13);
        check("R5 no strip when disabled", int'(out_valid), 1);
        check("R5 no event when disabled", int'(ev_xoff), 0);
        fifo_level = 8'd30; step(); step();
        check("R5 no request when disabled", int'(send_req), 0);
        fifo_level = 8'd0;
        cfg_enable = 1'b1; step();
        // equal characters
        cfg_xon_char = 8'h55; cfg_xoff_char = 8'h55;
        rx_byte(8'h55);
        check("R2 equal chars xoff only", int'(ev_xoff), 1);
        check("R2 equal chars no xon", int'(ev_xon), 0);
        step(); step();
        force_xon = 1'b1; step(); force_xon = 1'b0;
        cfg_xon_char = 8'h11; cfg_xoff_char = 8'h13;
        step(); step();
        // mixed traffic
        for (int c = 0; c < 4000; c++) begin
            int r;
            r = int'($urandom % 16);
            rx_valid = (r < 10);
            rx_data = (r < 3) ? 8'h11 : (r < 6) ? 8'h13 : 8'($urandom);
            tx_busy = ($urandom % 3) != 0;
            send_grant = ($urandom % 4) == 0;
            force_xon = ($urandom % 61) == 0;
            force_xoff = ($urandom % 67) == 0;
            if (($urandom % 200) == 0) cfg_enable = ~cfg_enable;
            if (($urandom % 150) == 0) cfg_strip = ~cfg_strip;
            if (($urandom % 2) == 0 && fifo_level < 8'd20) fifo_level = fifo_level + 1'b1;
            else if (fifo_level > 0) fifo_level = fifo_level - 1'b1;
            step();
        end
        rx_valid = 1'b0; force_xon = 1'b0; force_xoff = 1'b0;
        step();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule